// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the chip-level power mode state machine. It tracks which of seven operating modes the chip is in. There are three run modes: normal, high-speed and low-power. Normal run and low-power run each have a paired wait mode and a paired stop mode. From the current mode the block decodes the control lines that the clock, regulator, voltage-detect and wake logic elsewhere on the chip act on. Analog regulator behaviour, clock generation and retention circuits stay outside the block. It represents them only through these control lines.

Software changes the run mode through a mode request that carries a target code. The block checks the request against the set of legal transitions and answers an illegal one with a one-cycle error pulse. A sleep request, qualified by a deep-sleep select, moves the chip from a run mode into that run mode's wait or stop variant. Any enabled wake interrupt brings it back to the run mode it left. A fixed group of always-available low-power peripherals (oscillator, low-power timer, low-power serial port, real-time clock, comparator, touch sensing) is not gated by this block. Only the general peripheral clock and a parameterized set of optional peripheral clocks are gated here.

Top module: `pwr_mode_seq`

## Requirements
- R1: While rst_ni is low and right after it is released, mode_o is 0 (normal run), reg_lp_o is 0, lvd_en_o is 1, core, peripheral and interrupt-controller clocks are enabled, and mode_chg_o and req_err_o are 0.
- R2: mode_o reports the mode with this code: 0 normal run, 1 normal wait, 2 normal stop, 3 low-power run, 4 low-power wait, 5 low-power stop, 6 high-speed run. A transition that the inputs cause at a clock edge is visible on mode_o right after that edge.
- R3: In normal run or low-power run, sleep_req_i without mode_req_valid_i moves to that run mode's wait mode when deep_sel_i is 0, and to its stop mode when deep_sel_i is 1.
- R4: sleep_req_i has no effect in high-speed run or in any wait or stop mode.
- R5: In a wait or stop mode, any wake_irq_i bit whose irq_en_i bit is 1 returns the chip to the run mode the sleep was entered from. Wake bits whose enable is 0 have no effect, and wake bits have no effect in a run mode.
- R6: In both wait modes the core clock is off, and the peripheral clock, interrupt-controller enable and interrupt-controller clock stay on, with async_wake_en_o 0. In every run mode the core clock is on.
- R7: In normal stop, the core, peripheral and all optional clocks are off, intc_en_o and intc_clk_en_o are 0, async_wake_en_o is 1, lvd_en_o is 1 and reg_lp_o is 0. In low-power stop the same clock, interrupt and wake lines take the same values.
- R8: In the three low-power modes (codes 3, 4, 5), reg_lp_o is 1, lvd_en_o is 0 and flash_slow_o is 1. In all other modes these outputs are 0, 1 and 0.
- R9: opt_clk_en_o[i] equals src_en_i[i] in run and wait modes. It equals stop_en_i[i] AND src_en_i[i] in low-power stop, and it is 0 in normal stop.
- R10: mode_req_i codes are 0 normal run, 1 low-power run, 2 high-speed run and 3 reserved. In a run mode, a valid request is legal for normal run from any run mode, for low-power run from normal or low-power run, and for high-speed run from normal or high-speed run. A legal request moves to the target, and a request for the current mode leaves the mode unchanged. A valid mode request takes priority over sleep_req_i in the same cycle.
- R11: A valid mode request that is illegal (high-speed to low-power run, low-power to high-speed run, code 3, or any request in a wait or stop mode) leaves the run mode unchanged and raises req_err_o for exactly the cycle after the request.
- R12: mode_chg_o is 1 for exactly those cycles in which mode_o differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Wait-for-interrupt sleep request |
| deep_sel_i | input | 1 | Selects stop (1) or wait (0) on a sleep request |
| mode_req_valid_i | input | 1 | Mode-change request valid |
| mode_req_i | input | 2 | Target run mode code |
| wake_irq_i | input | N_IRQ | Wake interrupt lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enable |
| stop_en_i | input | N_OPT | Optional peripheral keeps its clock in low-power stop |
| src_en_i | input | N_OPT | Optional peripheral clock source enabled |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | General peripheral clock enable |
| opt_clk_en_o | output | N_OPT | Optional peripheral clock enables |
| reg_lp_o | output | 1 | Regulator low-power select |
| lvd_en_o | output | 1 | Low-voltage detect enable |
| intc_en_o | output | 1 | Interrupt controller enable |
| intc_clk_en_o | output | 1 | Fast interrupt-controller clock enable |
| async_wake_en_o | output | 1 | Asynchronous wake path enable |
| flash_slow_o | output | 1 | Reduced flash access clock select |
| mode_o | output | 3 | Current mode code |
| mode_chg_o | output | 1 | One-cycle mode-change strobe |
| req_err_o | output | 1 | One-cycle illegal-request pulse |

## Verification
Every control output is a pure decode of the registered mode. A wrong mode register therefore shows on mode_o and on at least one control line in the same cycle, one edge after the stimulus that caused it. A wrong legality decision appears one edge after the request, as an unexpected req_err_o pulse or a missing one, together with a missing or unexpected mode_chg_o. A lost record of the originating run mode shows only at the wake that follows, when mode_o lands on the wrong run code. For that reason the bench wakes from every wait and stop mode many times and compares mode_o on each of those wakes.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    M_NRUN  = 3'd0,
    M_NWAIT = 3'd1,
    M_NSTOP = 3'd2,
    M_LRUN  = 3'd3,
    M_LWAIT = 3'd4,
    M_LSTOP = 3'd5,
    M_HRUN  = 3'd6
  } pmode_e;

  typedef enum logic [1:0] {
    T_NORM = 2'd0,
    T_LOWP = 2'd1,
    T_HIGH = 2'd2,
    T_RSVD = 2'd3
  } tgt_e;

  typedef struct packed {
    logic core_clk;
    logic periph_clk;
    logic reg_lp;
    logic lvd_en;
    logic intc_en;
    logic intc_clk;
    logic async_wake;
    logic flash_slow;
    logic opt_gate;  // optional clocks follow stop enables
    logic opt_off;   // optional clocks forced off
  } ctrl_t;

  function automatic logic is_run(pmode_e m);
    return (m == M_NRUN) || (m == M_LRUN) || (m == M_HRUN);
  endfunction

  // run mode that a wait/stop mode returns to
  function automatic pmode_e home_of(pmode_e m);
    return ((m == M_LWAIT) || (m == M_LSTOP)) ? M_LRUN : M_NRUN;
  endfunction

endpackage

// File: rtl/pwr_req_check.sv
module pwr_req_check
  import pwr_mode_pkg::*;
(
  input  pmode_e     cur_i,
  input  logic [1:0] tgt_i,
  output logic       legal_o,
  output pmode_e     nxt_o
);
  tgt_e tgt;
  assign tgt = tgt_e'(tgt_i);

  always_comb begin
    legal_o = 1'b0;
    nxt_o   = cur_i;
    if (is_run(cur_i)) begin
      unique case (tgt)
        T_NORM: begin legal_o = 1'b1;              nxt_o = M_NRUN; end
        T_LOWP: begin legal_o = (cur_i != M_HRUN); nxt_o = M_LRUN; end
        T_HIGH: begin legal_o = (cur_i != M_LRUN); nxt_o = M_HRUN; end
        default: begin legal_o = 1'b0;             nxt_o = cur_i;  end
      endcase
      if (!legal_o) nxt_o = cur_i;
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sleep_i,
  input  logic   deep_i,
  input  logic   req_v_i,
  input  logic   legal_i,
  input  pmode_e req_nxt_i,
  input  logic   wake_i,
  output pmode_e mode_o,
  output logic   chg_o,
  output logic   err_o
);
  pmode_e mode_q, mode_d;
  logic   chg_q, err_q, err_d;

  always_comb begin
    mode_d = mode_q;
    err_d  = 1'b0;
    if (is_run(mode_q)) begin
      if (req_v_i) begin
        if (legal_i) mode_d = req_nxt_i;
        else         err_d  = 1'b1;
      end else if (sleep_i) begin
        unique case (mode_q)
          M_NRUN:  mode_d = deep_i ? M_NSTOP : M_NWAIT;
          M_LRUN:  mode_d = deep_i ? M_LSTOP : M_LWAIT;
          default: mode_d = mode_q;  // high-speed run: no sleep
        endcase
      end
    end else begin
      err_d = req_v_i;
      if (wake_i) mode_d = home_of(mode_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_NRUN;
      chg_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= (mode_d != mode_q);
      err_q  <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pwr_ctrl_decode.sv
module pwr_ctrl_decode
  import pwr_mode_pkg::*;
#(
  parameter int N_OPT = 2
) (
  input  pmode_e           mode_i,
  input  logic [N_OPT-1:0] stop_en_i,
  input  logic [N_OPT-1:0] src_en_i,
  output ctrl_t            ctrl_o,
  output logic [N_OPT-1:0] opt_clk_o
);
  always_comb begin
    // full-power run defaults
    ctrl_o = '{core_clk: 1'b1, periph_clk: 1'b1, reg_lp: 1'b0, lvd_en: 1'b1,
               intc_en: 1'b1, intc_clk: 1'b1, async_wake: 1'b0, flash_slow: 1'b0,
               opt_gate: 1'b0, opt_off: 1'b0};
    unique case (mode_i)
      M_NRUN, M_HRUN: ;
      M_NWAIT: ctrl_o.core_clk = 1'b0;
      M_NSTOP: begin
        ctrl_o.core_clk   = 1'b0;
        ctrl_o.periph_clk = 1'b0;
        ctrl_o.intc_en    = 1'b0;
        ctrl_o.intc_clk   = 1'b0;
        ctrl_o.async_wake = 1'b1;
        ctrl_o.opt_off    = 1'b1;
      end
      M_LRUN: begin
        ctrl_o.reg_lp     = 1'b1;
        ctrl_o.lvd_en     = 1'b0;
        ctrl_o.flash_slow = 1'b1;
      end
      M_LWAIT: begin
        ctrl_o.core_clk   = 1'b0;
        ctrl_o.reg_lp     = 1'b1;
        ctrl_o.lvd_en     = 1'b0;
        ctrl_o.flash_slow = 1'b1;
      end
      M_LSTOP: begin
        ctrl_o.core_clk   = 1'b0;
        ctrl_o.periph_clk = 1'b0;
        ctrl_o.reg_lp     = 1'b1;
        ctrl_o.lvd_en     = 1'b0;
        ctrl_o.intc_en    = 1'b0;
        ctrl_o.intc_clk   = 1'b0;
        ctrl_o.async_wake = 1'b1;
        ctrl_o.flash_slow = 1'b1;
        ctrl_o.opt_gate   = 1'b1;
      end
      default: begin  // unused code: safest static state
        ctrl_o.core_clk   = 1'b0;
        ctrl_o.periph_clk = 1'b0;
        ctrl_o.intc_en    = 1'b0;
        ctrl_o.intc_clk   = 1'b0;
        ctrl_o.async_wake = 1'b1;
        ctrl_o.opt_off    = 1'b1;
      end
    endcase
  end

  for (genvar i = 0; i < N_OPT; i++) begin : g_opt
    assign opt_clk_o[i] = src_en_i[i] & ~ctrl_o.opt_off & (~ctrl_o.opt_gate | stop_en_i[i]);
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_OPT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             deep_sel_i,
  input  logic             mode_req_valid_i,
  input  logic [1:0]       mode_req_i,
  input  logic [N_IRQ-1:0] wake_irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_OPT-1:0] stop_en_i,
  input  logic [N_OPT-1:0] src_en_i,
  output logic             core_clk_en_o,
  output logic             periph_clk_en_o,
  output logic [N_OPT-1:0] opt_clk_en_o,
  output logic             reg_lp_o,
  output logic             lvd_en_o,
  output logic             intc_en_o,
  output logic             intc_clk_en_o,
  output logic             async_wake_en_o,
  output logic             flash_slow_o,
  output logic [2:0]       mode_o,
  output logic             mode_chg_o,
  output logic             req_err_o
);
  pmode_e mode;
  pmode_e req_nxt;
  logic   req_legal;
  logic   wake_any;
  ctrl_t  ctrl;

  assign wake_any = |(wake_irq_i & irq_en_i);

  pwr_req_check u_req (
    .cur_i   (mode),
    .tgt_i   (mode_req_i),
    .legal_o (req_legal),
    .nxt_o   (req_nxt)
  );

  pwr_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_req_i),
    .deep_i    (deep_sel_i),
    .req_v_i   (mode_req_valid_i),
    .legal_i   (req_legal),
    .req_nxt_i (req_nxt),
    .wake_i    (wake_any),
    .mode_o    (mode),
    .chg_o     (mode_chg_o),
    .err_o     (req_err_o)
  );

  pwr_ctrl_decode #(.N_OPT(N_OPT)) u_dec (
    .mode_i    (mode),
    .stop_en_i (stop_en_i),
    .src_en_i  (src_en_i),
    .ctrl_o    (ctrl),
    .opt_clk_o (opt_clk_en_o)
  );

  assign mode_o          = mode;
  assign core_clk_en_o   = ctrl.core_clk;
  assign periph_clk_en_o = ctrl.periph_clk;
  assign reg_lp_o        = ctrl.reg_lp;
  assign lvd_en_o        = ctrl.lvd_en;
  assign intc_en_o       = ctrl.intc_en;
  assign intc_clk_en_o   = ctrl.intc_clk;
  assign async_wake_en_o = ctrl.async_wake;
  assign flash_slow_o    = ctrl.flash_slow;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_OPT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_req_i,
  input logic             deep_sel_i,
  input logic             mode_req_valid_i,
  input logic [N_IRQ-1:0] wake_irq_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             core_clk_en_o,
  input logic             periph_clk_en_o,
  input logic [N_OPT-1:0] opt_clk_en_o,
  input logic             reg_lp_o,
  input logic             lvd_en_o,
  input logic             intc_en_o,
  input logic             intc_clk_en_o,
  input logic             async_wake_en_o,
  input logic             flash_slow_o,
  input logic [2:0]       mode_o,
  input logic             mode_chg_o,
  input logic             req_err_o
);
  // R1
  reset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mode_o == M_NRUN));

  // R3
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_NRUN && sleep_req_i && !mode_req_valid_i)
      |=> (mode_o == (deep_sel_i ? M_NSTOP : M_NWAIT)) || $past(deep_sel_i) == deep_sel_i && 1'b0
        || (mode_o == ($past(deep_sel_i) ? M_NSTOP : M_NWAIT)));

  // R4
  hrun_sleep_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_HRUN && sleep_req_i && !mode_req_valid_i) |=> (mode_o == M_HRUN));

  // R5
  lwait_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_LWAIT || mode_o == M_LSTOP) && |(wake_irq_i & irq_en_i)) |=> (mode_o == M_LRUN));

  // R6
  lwait_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_LWAIT) |-> (!core_clk_en_o && intc_clk_en_o && intc_en_o && !async_wake_en_o));

  // R7
  nstop_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_NSTOP) |-> (!periph_clk_en_o && !intc_en_o && async_wake_en_o && lvd_en_o
                             && !reg_lp_o && (opt_clk_en_o == '0)));

  // R8
  lp_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_LRUN || mode_o == M_LWAIT || mode_o == M_LSTOP)
      |-> (reg_lp_o && !lvd_en_o && flash_slow_o));

  // R11
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> ($past(mode_req_valid_i) && !mode_chg_o) || ($past(mode_req_valid_i) && !$past(
      mode_o == M_NRUN || mode_o == M_LRUN || mode_o == M_HRUN)));

  // R12
  chg_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> mode_chg_o);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_IRQ(N_IRQ), .N_OPT(N_OPT)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .sleep_req_i      (sleep_req_i),
  .deep_sel_i       (deep_sel_i),
  .mode_req_valid_i (mode_req_valid_i),
  .wake_irq_i       (wake_irq_i),
  .irq_en_i         (irq_en_i),
  .core_clk_en_o    (core_clk_en_o),
  .periph_clk_en_o  (periph_clk_en_o),
  .opt_clk_en_o     (opt_clk_en_o),
  .reg_lp_o         (reg_lp_o),
  .lvd_en_o         (lvd_en_o),
  .intc_en_o        (intc_en_o),
  .intc_clk_en_o    (intc_clk_en_o),
  .async_wake_en_o  (async_wake_en_o),
  .flash_slow_o     (flash_slow_o),
  .mode_o           (mode_o),
  .mode_chg_o       (mode_chg_o),
  .req_err_o        (req_err_o)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 8;
  localparam int N_OPT = 2;
  localparam int N_RAND = 4000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req, deep_sel, req_v;
  logic [1:0] req_code;
  logic [N_IRQ-1:0] irq, irq_en;
  logic [N_OPT-1:0] stop_en, src_en;
  logic core_clk, periph_clk, reg_lp, lvd_en, intc_en, intc_clk, awake, flash_slow;
  logic [N_OPT-1:0] opt_clk;
  logic [2:0] mode;
  logic chg, err;

  int n_vec = 0;
  int n_bad = 0;
  int exp_mode = 0;
  int exp_chg = 0;
  int exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.N_IRQ(N_IRQ), .N_OPT(N_OPT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .deep_sel_i(deep_sel),
    .mode_req_valid_i(req_v), .mode_req_i(req_code), .wake_irq_i(irq), .irq_en_i(irq_en),
    .stop_en_i(stop_en), .src_en_i(src_en), .core_clk_en_o(core_clk),
    .periph_clk_en_o(periph_clk), .opt_clk_en_o(opt_clk), .reg_lp_o(reg_lp),
    .lvd_en_o(lvd_en), .intc_en_o(intc_en), .intc_clk_en_o(intc_clk),
    .async_wake_en_o(awake), .flash_slow_o(flash_slow), .mode_o(mode),
    .mode_chg_o(chg), .req_err_o(err)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int is_lp(int m);  return (m == 3 || m == 4 || m == 5) ? 1 : 0; endfunction
  function automatic int is_stp(int m); return (m == 2 || m == 5) ? 1 : 0; endfunction
  function automatic int is_rn(int m);  return (m == 0 || m == 3 || m == 6) ? 1 : 0; endfunction

  function automatic int exp_opt(int m, logic [N_OPT-1:0] se, logic [N_OPT-1:0] sr);
    if (m == 2) return 0;
    if (m == 5) return int'(se & sr);
    return int'(sr);
  endfunction

  task automatic check_all();
    chk("R2",  "mode",       int'(mode),       exp_mode);
    chk("R12", "mode_chg",   int'(chg),        exp_chg);
    chk("R11", "req_err",    int'(err),        exp_err);
    chk("R6",  "core_clk",   int'(core_clk),   is_rn(exp_mode));
    chk("R7",  "periph_clk", int'(periph_clk), 1 - is_stp(exp_mode));
    chk("R6",  "intc_en",    int'(intc_en),    1 - is_stp(exp_mode));
    chk("R6",  "intc_clk",   int'(intc_clk),   1 - is_stp(exp_mode));
    chk("R7",  "async_wake", int'(awake),      is_stp(exp_mode));
    chk("R8",  "reg_lp",     int'(reg_lp),     is_lp(exp_mode));
    chk("R8",  "lvd_en",     int'(lvd_en),     1 - is_lp(exp_mode));
    chk("R8",  "flash_slow", int'(flash_slow), is_lp(exp_mode));
    chk("R9",  "opt_clk",    int'(opt_clk),    exp_opt(exp_mode, stop_en, src_en));
  endtask

  // model: next mode and error from current mode and present inputs
  task automatic model();
    int nm = exp_mode;
    int ne = 0;
    if (is_rn(exp_mode) == 1) begin
      if (req_v) begin
        if (req_code == 2'd0) nm = 0;
        else if (req_code == 2'd1 && exp_mode != 6) nm = 3;
        else if (req_code == 2'd2 && exp_mode != 3) nm = 6;
        else ne = 1;
      end else if (sleep_req && exp_mode != 6) begin
        nm = exp_mode + (deep_sel ? 2 : 1);
      end
    end else begin
      ne = req_v ? 1 : 0;
      if ((irq & irq_en) != '0) nm = (exp_mode >= 4) ? 3 : 0;
    end
    exp_chg  = (nm != exp_mode) ? 1 : 0;
    exp_err  = ne;
    exp_mode = nm;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    check_all();
    sleep_req = 1'b0; req_v = 1'b0; irq = '0;
  endtask

  task automatic expect_mode(string req, int m);
    chk(req, "directed mode", int'(mode), m);
  endtask

  task automatic do_sleep(logic deep);
    sleep_req = 1'b1; deep_sel = deep; step();
  endtask

  task automatic do_req(logic [1:0] c);
    req_v = 1'b1; req_code = c; step();
  endtask

  task automatic do_wake(logic [N_IRQ-1:0] v);
    irq = v; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R2 watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    sleep_req = 1'b0; deep_sel = 1'b0; req_v = 1'b0; req_code = 2'd0;
    irq = '0; irq_en = '1; stop_en = '0; src_en = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset mode", int'(mode), 0);
    chk("R1", "reset reg_lp", int'(reg_lp), 0);
    chk("R1", "reset lvd", int'(lvd_en), 1);
    chk("R1", "reset core_clk", int'(core_clk), 1);
    chk("R1", "reset strobes", int'({chg, err}), 0);
    rst_ni = 1'b1;
    step();
    chk("R1", "after release mode", int'(mode), 0);

    // R3 / R12: sleep into normal wait, strobe for one cycle
    do_sleep(1'b0); expect_mode("R3", 1); chk("R12", "strobe on", int'(chg), 1);
    step();         chk("R12", "strobe off", int'(chg), 0);
    // R4: sleep in wait ignored
    do_sleep(1'b1); expect_mode("R4", 1);
    // R5: masked wake ignored, enabled wake returns
    irq_en = 8'h0F;
    do_wake(8'hF0); expect_mode("R5", 1);
    do_wake(8'h10 | 8'h01); expect_mode("R5", 0);
    // R5: irq in run mode has no effect
    do_wake(8'hFF); expect_mode("R5", 0);

    // R10: to low-power run, then low-power stop with optional clocks
    do_req(2'd1); expect_mode("R10", 3);
    stop_en = 2'b01; src_en = 2'b11;
    do_sleep(1'b1); expect_mode("R3", 5);
    chk("R9", "lstop opt", int'(opt_clk), 1);
    src_en = 2'b10; step(); chk("R9", "lstop src off", int'(opt_clk), 0);
    src_en = 2'b11;
    // R11: request while stopped
    do_req(2'd0); expect_mode("R11", 5); chk("R11", "err in stop", int'(err), 1);
    do_wake(8'h01); expect_mode("R5", 3);
    // R6: low-power wait
    do_sleep(1'b0); expect_mode("R3", 4);
    chk("R6", "lwait core", int'(core_clk), 0); chk("R6", "lwait intc_clk", int'(intc_clk), 1);
    do_wake(8'h02); expect_mode("R5", 3);
    // R11: low-power to high-speed illegal
    do_req(2'd2); expect_mode("R11", 3); chk("R11", "err lp->hs", int'(err), 1);
    step(); chk("R11", "err one cycle", int'(err), 0);
    // R10: back to normal, up to high-speed
    do_req(2'd0); expect_mode("R10", 0);
    do_req(2'd2); expect_mode("R10", 6);
    do_sleep(1'b1); expect_mode("R4", 6);
    do_req(2'd1); expect_mode("R11", 6); chk("R11", "err hs->lp", int'(err), 1);
    do_req(2'd3); expect_mode("R11", 6); chk("R11", "err rsvd", int'(err), 1);
    do_req(2'd2); expect_mode("R10", 6); chk("R10", "same mode no strobe", int'({chg, err}), 0);
    do_req(2'd0); expect_mode("R10", 0);
    // R7: normal stop
    do_sleep(1'b1); expect_mode("R7", 2);
    chk("R7", "nstop lvd", int'(lvd_en), 1); chk("R7", "nstop opt", int'(opt_clk), 0);
    do_wake(8'h08); expect_mode("R5", 0);
    // R10: request beats sleep in the same cycle
    sleep_req = 1'b1; deep_sel = 1'b1; do_req(2'd1); expect_mode("R10", 3);
    chk("R8", "lrun flash", int'(flash_slow), 1);
    do_req(2'd0); expect_mode("R10", 0);

    // constrained random
    for (int i = 0; i < N_RAND; i++) begin
      sleep_req = ($urandom % 4) == 0;
      deep_sel  = $urandom % 2;
      req_v     = ($urandom % 6) == 0;
      req_code  = 2'($urandom % 4);
      irq       = (($urandom % 5) == 0) ? N_IRQ'($urandom) : '0;
      if (($urandom % 16) == 0) irq_en  = N_IRQ'($urandom);
      if (($urandom % 16) == 0) stop_en = N_OPT'($urandom);
      if (($urandom % 16) == 0) src_en  = N_OPT'($urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule